// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

This block joins two eight-input priority interrupt controllers into a sixteen-line interrupt source. One controller is the master and the other is the slave. The slave's request output feeds the master's input 2. Request lines 0 to 7 go to master inputs 0 to 7, and lines 8 to 15 go to slave inputs 0 to 7.

Each request line passes through a synchronizer. Its rising and falling edges are detected against the previous synchronized sample. Each controller keeps four sets of state: pending requests, a mask, the inputs currently in service, and a trigger-mode register that selects edge or level behaviour for each input. A byte command port drives each controller's initialization sequence, its mask writes and its end-of-service commands.

An acknowledge strobe returns a registered result: the interrupt line number and an 8-bit vector. The vector is the owning controller's programmed base plus the input index. When the master's input 2 wins, the slave is acknowledged in the same cycle.

Top module: `casc_irq_pair`

## Requirements
- R1: A rising edge on a synchronized request line sets that input's pending bit, and a falling edge clears it. With the line unmasked and nothing in service, `int_out` changes after the third rising clock edge following the change on the line.
- R2: A trigger-mode write stores `lvl_data & 0xF8` on the master and `lvl_data & 0xDE` on the slave. A 1 selects level mode. Bits outside these masks behave as edge-triggered. Master input 2 always behaves as level-triggered, yet it reads back as 0.
- R3: Master input 2 follows the slave's internal request output: it rises when the slave output rises and clears when the slave output falls. `int_out` is then re-evaluated.
- R4: Edges on external line 2 are ignored; that input is reserved for the cascade. Slave input 2 (line 10) works normally.
- R5: On acknowledge, an edge-mode input clears its pending bit and a level-mode input keeps it. A level request therefore raises `int_out` again once its in-service bit is cleared.
- R6: When the master's winning input is 2, the slave's winning input is acknowledged as well. `ack_line` is then 8 plus the slave index, with bit 3 set.
- R7: `ack_vector` is bits 7:3 of the owning controller's base byte, with the 3-bit input index in bits 2:0.
- R8: After reset, both trigger-mode reads, `int_out`, `ack_done`, `ack_valid`, `ack_line` and `ack_vector` are 0. All masks, pending bits and in-service bits are clear.
- R9: An acknowledge while `int_out` is low returns `ack_valid`=0, `ack_line`=4'hF and `ack_vector`=8'hFF, and changes no state.
- R10: Input 0 has the highest priority and input 7 the lowest. A masked input never raises a request. An unmasked pending input raises a request only if it has a higher priority than every in-service input.
- R11: An initialization word has `cmd_a0`=0 and data bit 4 set. It clears the mask and the in-service bits, and clears the pending bits of edge-mode inputs. The data words that follow (`cmd_a0`=1) are taken in order: the base; a cascade word, skipped when bit 1 of the initialization word is set; and a mode word, expected only when bit 0 of the initialization word is set. Bit 1 of the mode word selects automatic end of service, in which an acknowledge sets no in-service bit. Once the sequence is complete, a data word writes the mask.
- R12: A command with `cmd_a0`=0 and data bits 4 and 3 clear is an end-of-service command. Data bits 7:5 = 001 clear the highest-priority in-service bit. Data bits 7:5 = 011 clear the in-service bit named by data bits 2:0.
- R13: An acknowledge is decided on the pending state as it stood before any request edge that lands in the same clock cycle. An edge in that cycle is kept and is judged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Asynchronous request lines |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_slave | input | 1 | Command targets the slave (1) or the master (0) |
| cmd_a0 | input | 1 | Command address bit: 0 selects init or end-of-service commands, 1 selects data words |
| cmd_data | input | 8 | Command byte |
| lvl_wr | input | 1 | Trigger-mode write strobe |
| lvl_slave | input | 1 | Trigger-mode write targets the slave (1) or the master (0) |
| lvl_data | input | 8 | Trigger-mode write data |
| lvl_rd_master | output | 8 | Master trigger-mode readback |
| lvl_rd_slave | output | 8 | Slave trigger-mode readback |
| int_out | output | 1 | Master request output |
| ack_req | input | 1 | Acknowledge strobe |
| ack_done | output | 1 | One-cycle pulse after an acknowledge |
| ack_valid | output | 1 | The acknowledge found a request |
| ack_line | output | 4 | Acknowledged line number, 4'hF if none |
| ack_vector | output | 8 | Acknowledged vector, 8'hFF if none |

## Verification
An acknowledge and a request edge can land in the same clock cycle. The edge may come either from the synchronizer or from the slave, through master input 2. The bench counts the synchronizer stages so that a higher-priority line's rising edge is detected in exactly the cycle the acknowledge strobe is sampled. It then expects the result to name the older, lower-priority request. It also expects `int_out` to stay high for the newly captured line, and a second acknowledge to return that line.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_BASE  = 2'd1,
      ST_CASC  = 2'd2,
      ST_MODE  = 2'd3
   } init_step_e;

   typedef struct packed {
      logic init_start;
      logic mask_wr;
      logic base_wr;
      logic casc_wr;
      logic mode_wr;
      logic eoi_top;
      logic eoi_named;
   } cmd_dec_t;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   if (STAGES < 1) begin : g_bad_stages
      $error("irq_edge_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;
   logic [WIDTH-1:0]             prev_q;
   logic [WIDTH-1:0]             synced;

   assign synced = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
         prev_q <= synced;
      end
   end

   assign rise = synced & ~prev_q;
   assign fall = ~synced & prev_q;
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
   parameter int unsigned LINES = 8,
   localparam int unsigned IDX_W = $clog2(LINES)
)(
   input  logic [LINES-1:0] req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
   import casc_irq_pkg::*;
(
   input  logic       wr,
   input  logic       a0,
   input  logic [7:0] data,
   input  init_step_e step,
   output cmd_dec_t   dec
);
   always_comb begin
      dec = '0;
      if (wr) begin
         if (!a0) begin
            if (data[4]) begin
               dec.init_start = 1'b1;
            end else if (!data[3]) begin
               if (data[7:5] == 3'b001) dec.eoi_top   = 1'b1;
               if (data[7:5] == 3'b011) dec.eoi_named = 1'b1;
            end
         end else begin
            case (step)
               ST_READY: dec.mask_wr = 1'b1;
               ST_BASE:  dec.base_wr = 1'b1;
               ST_CASC:  dec.casc_wr = 1'b1;
               default:  dec.mode_wr = 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
   import casc_irq_pkg::*;
#(
   parameter int unsigned      LINES     = 8,
   parameter bit               IS_MASTER = 1'b0,
   parameter int unsigned      CASC_IDX  = 2,
   parameter logic [LINES-1:0] LVL_WMASK = '1,
   parameter logic [LINES-1:0] LVL_FORCE = '0,
   localparam int unsigned     IDX_W     = $clog2(LINES),
   localparam int unsigned     BASE_W    = 8 - IDX_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] rise,
   input  logic [LINES-1:0] fall,
   input  logic             casc_req,
   input  logic             cmd_wr,
   input  logic             cmd_a0,
   input  logic [7:0]       cmd_data,
   input  logic             lvl_wr,
   input  logic [LINES-1:0] lvl_data,
   output logic [LINES-1:0] lvl_rd,
   input  logic             take,
   output logic             int_o,
   output logic [IDX_W-1:0] sel_idx,
   output logic [7:0]       vec_o
);
   localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_IDX;

   logic [LINES-1:0]  irr_q, imr_q, isr_q, lvl_q;
   logic [LINES-1:0]  irr_d, imr_d, isr_d;
   logic [BASE_W-1:0] base_q, base_d;
   init_step_e        step_q, step_d;
   logic              need_mode_q, need_mode_d;
   logic              single_q, single_d;
   logic              aeoi_q, aeoi_d;

   logic [LINES-1:0]  req_eff, rise_m, fall_m, pend, lvl_eff;
   logic              p_found, s_found;
   logic [IDX_W-1:0]  p_idx, s_idx;
   cmd_dec_t          dec;

   if (IS_MASTER) begin : g_master
      assign req_eff = (irr_q & ~CASC_BIT) | (casc_req ? CASC_BIT : '0);
      assign rise_m  = rise & ~CASC_BIT;
      assign fall_m  = fall & ~CASC_BIT;
   end else begin : g_slave
      logic unused_casc;
      assign unused_casc = casc_req;
      assign req_eff = irr_q;
      assign rise_m  = rise;
      assign fall_m  = fall;
   end

   assign lvl_eff = lvl_q | LVL_FORCE;
   assign lvl_rd  = lvl_q;
   assign pend    = req_eff & ~imr_q;

   irq_prio_resolve #(.LINES(LINES)) u_pend_res (
      .req(pend), .found(p_found), .idx(p_idx));
   irq_prio_resolve #(.LINES(LINES)) u_isr_res (
      .req(isr_q), .found(s_found), .idx(s_idx));
   irq_cmd_decode u_dec (
      .wr(cmd_wr), .a0(cmd_a0), .data(cmd_data), .step(step_q), .dec(dec));

   assign int_o   = p_found && (!s_found || (p_idx < s_idx));
   assign sel_idx = p_idx;
   assign vec_o   = {base_q, p_idx};

   always_comb begin
      irr_d       = irr_q;
      imr_d       = imr_q;
      isr_d       = isr_q;
      base_d      = base_q;
      step_d      = step_q;
      need_mode_d = need_mode_q;
      single_d    = single_q;
      aeoi_d      = aeoi_q;
      // acknowledge uses pre-edge state, then this cycle's edges apply
      if (take) begin
         if (!lvl_eff[p_idx]) irr_d[p_idx] = 1'b0;
         if (!aeoi_q)         isr_d[p_idx] = 1'b1;
      end
      irr_d = (irr_d & ~fall_m) | rise_m;
      if (dec.eoi_top && s_found) isr_d[s_idx] = 1'b0;
      if (dec.eoi_named) isr_d[cmd_data[IDX_W-1:0]] = 1'b0;
      if (dec.mask_wr) imr_d = cmd_data[LINES-1:0];
      if (dec.base_wr) begin
         base_d = cmd_data[7 -: BASE_W];
         step_d = single_q ? (need_mode_q ? ST_MODE : ST_READY) : ST_CASC;
      end
      if (dec.casc_wr) step_d = need_mode_q ? ST_MODE : ST_READY;
      if (dec.mode_wr) begin
         aeoi_d = cmd_data[1];
         step_d = ST_READY;
      end
      if (dec.init_start) begin
         irr_d       = irr_d & lvl_eff;
         imr_d       = '0;
         isr_d       = '0;
         need_mode_d = cmd_data[0];
         single_d    = cmd_data[1];
         if (!cmd_data[0]) aeoi_d = 1'b0;
         step_d      = ST_BASE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q       <= '0;
         imr_q       <= '0;
         isr_q       <= '0;
         lvl_q       <= '0;
         base_q      <= '0;
         step_q      <= ST_READY;
         need_mode_q <= 1'b0;
         single_q    <= 1'b0;
         aeoi_q      <= 1'b0;
      end else begin
         irr_q       <= irr_d;
         imr_q       <= imr_d;
         isr_q       <= isr_d;
         base_q      <= base_d;
         step_q      <= step_d;
         need_mode_q <= need_mode_d;
         single_q    <= single_d;
         aeoi_q      <= aeoi_d;
         if (lvl_wr) lvl_q <= lvl_data & LVL_WMASK;
      end
   end
endmodule

// File: rtl/casc_irq_pair.sv
module casc_irq_pair #(
   parameter int unsigned LINES       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CASC_IDX    = 2,
   parameter logic [LINES-1:0] M_LVL_WMASK = 8'hF8,
   parameter logic [LINES-1:0] S_LVL_WMASK = 8'hDE,
   localparam int unsigned IDX_W  = $clog2(LINES),
   localparam int unsigned TOTAL  = 2 * LINES,
   localparam int unsigned LINE_W = IDX_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TOTAL-1:0]  irq_in,
   input  logic              cmd_wr,
   input  logic              cmd_slave,
   input  logic              cmd_a0,
   input  logic [7:0]        cmd_data,
   input  logic              lvl_wr,
   input  logic              lvl_slave,
   input  logic [LINES-1:0]  lvl_data,
   output logic [LINES-1:0]  lvl_rd_master,
   output logic [LINES-1:0]  lvl_rd_slave,
   output logic              int_out,
   input  logic              ack_req,
   output logic              ack_done,
   output logic              ack_valid,
   output logic [LINE_W-1:0] ack_line,
   output logic [7:0]        ack_vector
);
   if ((LINES != (1 << IDX_W)) || (LINES > 8) || (LINES < 2)) begin : g_bad_lines
      $error("casc_irq_pair: LINES must be a power of two from 2 to 8");
   end
   if (CASC_IDX >= LINES) begin : g_bad_casc
      $error("casc_irq_pair: CASC_IDX out of range");
   end

   localparam logic [IDX_W-1:0] CASC_SEL = IDX_W'(CASC_IDX);
   localparam logic [LINES-1:0] M_FORCE  = LINES'(1) << CASC_IDX;

   logic [TOTAL-1:0] rise, fall;
   logic             m_int, s_int, m_take, s_take;
   logic [IDX_W-1:0] m_idx, s_idx;
   logic [7:0]       m_vec, s_vec;

   irq_edge_sync #(.WIDTH(TOTAL), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(irq_in), .rise(rise), .fall(fall));

   assign m_take = ack_req & m_int;
   assign s_take = m_take & (m_idx == CASC_SEL);

   irq_ctrl_core #(
      .LINES(LINES), .IS_MASTER(1'b1), .CASC_IDX(CASC_IDX),
      .LVL_WMASK(M_LVL_WMASK & ~M_FORCE), .LVL_FORCE(M_FORCE)
   ) u_master (
      .clk(clk), .rst_n(rst_n),
      .rise(rise[LINES-1:0]), .fall(fall[LINES-1:0]), .casc_req(s_int),
      .cmd_wr(cmd_wr & ~cmd_slave), .cmd_a0(cmd_a0), .cmd_data(cmd_data),
      .lvl_wr(lvl_wr & ~lvl_slave), .lvl_data(lvl_data), .lvl_rd(lvl_rd_master),
      .take(m_take), .int_o(m_int), .sel_idx(m_idx), .vec_o(m_vec));

   irq_ctrl_core #(
      .LINES(LINES), .IS_MASTER(1'b0), .CASC_IDX(CASC_IDX),
      .LVL_WMASK(S_LVL_WMASK), .LVL_FORCE('0)
   ) u_slave (
      .clk(clk), .rst_n(rst_n),
      .rise(rise[TOTAL-1:LINES]), .fall(fall[TOTAL-1:LINES]), .casc_req(1'b0),
      .cmd_wr(cmd_wr & cmd_slave), .cmd_a0(cmd_a0), .cmd_data(cmd_data),
      .lvl_wr(lvl_wr & lvl_slave), .lvl_data(lvl_data), .lvl_rd(lvl_rd_slave),
      .take(s_take), .int_o(s_int), .sel_idx(s_idx), .vec_o(s_vec));

   assign int_out = m_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_done   <= 1'b0;
         ack_valid  <= 1'b0;
         ack_line   <= '0;
         ack_vector <= '0;
      end else begin
         ack_done <= ack_req;
         if (ack_req) begin
            if (m_take && s_take) begin
               ack_valid  <= 1'b1;
               ack_line   <= {1'b1, s_idx};
               ack_vector <= s_vec;
            end else if (m_take) begin
               ack_valid  <= 1'b1;
               ack_line   <= {1'b0, m_idx};
               ack_vector <= m_vec;
            end else begin
               ack_valid  <= 1'b0;
               ack_line   <= '1;
               ack_vector <= '1;
            end
         end else begin
            ack_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/casc_irq_pair_chk.sv
module casc_irq_pair_chk #(
   parameter int unsigned      LINES    = 8,
   parameter int unsigned      CASC_IDX = 2,
   parameter logic [LINES-1:0] M_WMASK  = 8'hF8,
   localparam int unsigned     IDX_W    = $clog2(LINES),
   localparam int unsigned     LINE_W   = IDX_W + 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              lvl_wr,
   input logic              lvl_slave,
   input logic [LINES-1:0]  lvl_data,
   input logic [LINES-1:0]  lvl_rd_master,
   input logic              int_out,
   input logic              ack_req,
   input logic              ack_done,
   input logic              ack_valid,
   input logic [LINE_W-1:0] ack_line,
   input logic [7:0]        ack_vector
);
   localparam logic [IDX_W-1:0] CASC_SEL = IDX_W'(CASC_IDX);
   localparam logic [LINES-1:0] M_FORCE  = LINES'(1) << CASC_IDX;

   assert_lvl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_wr && !lvl_slave) |=> (lvl_rd_master == ($past(lvl_data) & M_WMASK & ~M_FORCE)));

   assert_none_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !int_out) |=> (ack_done && !ack_valid && (ack_vector == 8'hFF)));

   assert_ack_found_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && int_out) |=> ack_valid);

   assert_no_casc_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_line[LINE_W-1]) |-> (ack_line[IDX_W-1:0] != CASC_SEL));

   assert_vec_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (ack_vector[IDX_W-1:0] == ack_line[IDX_W-1:0]));

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ack_done);
endmodule

bind casc_irq_pair casc_irq_pair_chk #(
   .LINES(LINES), .CASC_IDX(CASC_IDX), .M_WMASK(M_LVL_WMASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lvl_wr(lvl_wr), .lvl_slave(lvl_slave),
   .lvl_data(lvl_data), .lvl_rd_master(lvl_rd_master), .int_out(int_out),
   .ack_req(ack_req), .ack_done(ack_done), .ack_valid(ack_valid),
   .ack_line(ack_line), .ack_vector(ack_vector));

// File: tb/casc_irq_pair_tb_top.sv
module casc_irq_pair_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = '0;
   logic        cmd_wr = 1'b0, cmd_slave = 1'b0, cmd_a0 = 1'b0;
   logic [7:0]  cmd_data = '0;
   logic        lvl_wr = 1'b0, lvl_slave = 1'b0;
   logic [7:0]  lvl_data = '0;
   logic [7:0]  lvl_rd_master, lvl_rd_slave;
   logic        int_out, ack_req = 1'b0, ack_done, ack_valid;
   logic [3:0]  ack_line;
   logic [7:0]  ack_vector;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   casc_irq_pair dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .cmd_wr(cmd_wr), .cmd_slave(cmd_slave), .cmd_a0(cmd_a0), .cmd_data(cmd_data),
      .lvl_wr(lvl_wr), .lvl_slave(lvl_slave), .lvl_data(lvl_data),
      .lvl_rd_master(lvl_rd_master), .lvl_rd_slave(lvl_rd_slave),
      .int_out(int_out), .ack_req(ack_req), .ack_done(ack_done),
      .ack_valid(ack_valid), .ack_line(ack_line), .ack_vector(ack_vector));

   // {line[11:8], expected vector[7:0]} with master base 0x20, slave base 0x28
   localparam logic [11:0] VEC_TABLE [8] = '{
      {4'd0, 8'h20}, {4'd1, 8'h21}, {4'd5, 8'h25}, {4'd7, 8'h27},
      {4'd8, 8'h28}, {4'd9, 8'h29}, {4'd10, 8'h2A}, {4'd15, 8'h2F}};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cmd(input logic slave, input logic a0, input logic [7:0] d);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_slave = slave; cmd_a0 = a0; cmd_data = d;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic wr_lvl(input logic slave, input logic [7:0] d);
      @(negedge clk);
      lvl_wr = 1'b1; lvl_slave = slave; lvl_data = d;
      @(negedge clk);
      lvl_wr = 1'b0;
   endtask

   task automatic set_line(input int ln, input logic v);
      @(negedge clk);
      irq_in[ln] = v;
   endtask

   task automatic do_ack();
      @(negedge clk);
      ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
   endtask

   task automatic ack_expect(input string req, input int ln, input int vec);
      do_ack();
      chk(req, ack_valid, 1);
      chk(req, ack_line, ln);
      chk(req, ack_vector, vec);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R8 reset state
      chk("R8 int", int_out, 0);
      chk("R8 ack_valid", ack_valid, 0);
      chk("R8 ack_vector", ack_vector, 0);
      chk("R8 lvl master", lvl_rd_master, 0);
      chk("R8 lvl slave", lvl_rd_slave, 0);

      // R11 init: cascade form with mode word
      wr_cmd(0, 0, 8'h11); wr_cmd(0, 1, 8'h20); wr_cmd(0, 1, 8'h04); wr_cmd(0, 1, 8'h01);
      wr_cmd(1, 0, 8'h11); wr_cmd(1, 1, 8'h28); wr_cmd(1, 1, 8'h02); wr_cmd(1, 1, 8'h01);

      // R9 acknowledge with nothing pending
      do_ack();
      chk("R9 done", ack_done, 1);
      chk("R9 valid", ack_valid, 0);
      chk("R9 vector", ack_vector, 8'hFF);
      chk("R9 line", ack_line, 4'hF);

      // table walk over master and slave lines
      for (int k = 0; k < 8; k++) begin
         int ln;
         ln = int'(VEC_TABLE[k][11:8]);
         set_line(ln, 1'b1);
         cyc(4);
         chk(ln >= 8 ? "R3 int via cascade" : "R1 int on edge", int_out, 1);
         ack_expect(ln >= 8 ? "R6 cascade ack" : "R7 master ack", ln, int'(VEC_TABLE[k][7:0]));
         set_line(ln, 1'b0);
         cyc(4);
         if (ln >= 8) wr_cmd(1, 0, 8'h20);
         wr_cmd(0, 0, 8'h20);
         chk("R12 int after end of service", int_out, 0);
      end

      // R4 external line 2 ignored
      set_line(2, 1'b1);
      cyc(4);
      chk("R4 int", int_out, 0);
      do_ack();
      chk("R4 ack", ack_valid, 0);
      set_line(2, 1'b0);

      // R1 falling edge clears the request
      set_line(7, 1'b1);
      cyc(4);
      chk("R1 rise", int_out, 1);
      set_line(7, 1'b0);
      cyc(4);
      chk("R1 fall", int_out, 0);

      // R3 slave output follows into master input 2
      set_line(9, 1'b1);
      cyc(4);
      chk("R3 up", int_out, 1);
      wr_cmd(1, 1, 8'h02);
      chk("R3 slave masked drops master", int_out, 0);
      wr_cmd(1, 1, 8'h00);
      chk("R3 slave unmasked", int_out, 1);
      ack_expect("R6 line 9", 9, 8'h29);
      set_line(9, 1'b0);
      wr_cmd(1, 0, 8'h20); wr_cmd(0, 0, 8'h20);

      // R9 no state change, R10 mask
      wr_cmd(0, 1, 8'h40);
      set_line(6, 1'b1);
      cyc(4);
      chk("R10 masked", int_out, 0);
      do_ack();
      chk("R9 none while masked", ack_valid, 0);
      wr_cmd(0, 1, 8'h00);
      chk("R9 request kept", int_out, 1);
      ack_expect("R9 later ack", 6, 8'h26);
      set_line(6, 1'b0);
      wr_cmd(0, 0, 8'h20);

      // R10 priority order and in-service blocking
      @(negedge clk); irq_in[6] = 1'b1; irq_in[3] = 1'b1;
      cyc(4);
      ack_expect("R10 highest first", 3, 8'h23);
      chk("R10 lower blocked", int_out, 0);
      wr_cmd(0, 0, 8'h20);
      chk("R10 unblocked", int_out, 1);
      ack_expect("R10 second", 6, 8'h26);
      @(negedge clk); irq_in[6] = 1'b0; irq_in[3] = 1'b0;
      wr_cmd(0, 0, 8'h20);

      // R12 named end of service
      set_line(3, 1'b1); cyc(4);
      ack_expect("R12 take 3", 3, 8'h23);
      set_line(1, 1'b1); cyc(4);
      chk("R10 higher preempts", int_out, 1);
      ack_expect("R12 take 1", 1, 8'h21);
      wr_cmd(0, 0, 8'h63);
      set_line(4, 1'b1); cyc(4);
      chk("R12 line 1 still in service", int_out, 0);
      wr_cmd(0, 0, 8'h20);
      chk("R12 top cleared", int_out, 1);
      ack_expect("R12 take 4", 4, 8'h24);
      wr_cmd(0, 0, 8'h20);
      @(negedge clk); irq_in[1] = 1'b0; irq_in[3] = 1'b0; irq_in[4] = 1'b0;
      cyc(4);
      chk("R12 idle", int_out, 0);

      // R2 trigger-mode register, R5 level keeps request
      wr_lvl(0, 8'hFF);
      wr_lvl(1, 8'hFF);
      chk("R2 master read", lvl_rd_master, 8'hF8);
      chk("R2 slave read", lvl_rd_slave, 8'hDE);
      set_line(3, 1'b1); cyc(4);
      ack_expect("R5 level ack", 3, 8'h23);
      chk("R5 in service blocks", int_out, 0);
      wr_cmd(0, 0, 8'h20);
      chk("R5 level reasserts", int_out, 1);
      ack_expect("R5 level again", 3, 8'h23);
      set_line(3, 1'b0); cyc(4);
      wr_cmd(0, 0, 8'h20);
      chk("R5 level dropped", int_out, 0);
      set_line(0, 1'b1); cyc(4);
      ack_expect("R2 bit 0 edge", 0, 8'h20);
      wr_cmd(0, 0, 8'h20);
      chk("R2 bit 0 edge cleared", int_out, 0);
      set_line(0, 1'b0);
      wr_lvl(0, 8'h00);
      wr_lvl(1, 8'h00);

      // R13 edge lands in the acknowledge cycle
      set_line(5, 1'b1); cyc(4);
      @(negedge clk); irq_in[1] = 1'b1;
      @(negedge clk);
      @(negedge clk); ack_req = 1'b1;
      @(negedge clk); ack_req = 1'b0;
      chk("R13 older request wins", ack_line, 5);
      chk("R13 new edge kept", int_out, 1);
      ack_expect("R13 new line next", 1, 8'h21);
      @(negedge clk); irq_in[1] = 1'b0; irq_in[5] = 1'b0;
      wr_cmd(0, 0, 8'h20); wr_cmd(0, 0, 8'h20);
      cyc(4);
      chk("R13 idle", int_out, 0);

      // R11 re-init: single form, automatic end of service, base low bits dropped
      wr_cmd(0, 1, 8'hFF);
      wr_cmd(0, 0, 8'h13); wr_cmd(0, 1, 8'h47); wr_cmd(0, 1, 8'h03);
      set_line(4, 1'b1); cyc(4);
      chk("R11 mask cleared", int_out, 1);
      ack_expect("R7 new base", 4, 8'h44);
      set_line(6, 1'b1); cyc(4);
      chk("R11 auto end of service", int_out, 1);
      ack_expect("R11 second", 6, 8'h46);
      @(negedge clk); irq_in[4] = 1'b0; irq_in[6] = 1'b0;
      cyc(4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule